// File: doc/BRIEF.md
# Multi-Source Interrupt Request Router

This block gathers six interrupt causes from a data-acquisition board and turns them into a single request on one host interrupt line. The six causes are:

- the A/D converter FIFO asking for service;
- the end of an acquisition run, which also covers its error endings;
- a DMA terminal count on either of two channels;
- the D/A converter FIFO asking for service;
- the end of a waveform sequence, which also covers an underflow ending;
- a falling edge on the converter update strobe.

Each cause latches a sticky pending flag. Each flag is cleared on its own by a write-one-to-clear access. A per-cause enable mask decides which pending flags may raise the request.

The request goes out on one of eight host lines, chosen by a 3-bit field in a configuration register. The lines, in select order, are IRQ3, IRQ4, IRQ5, IRQ7, IRQ10, IRQ11, IRQ12 and IRQ15. Every line is tri-state: it is driven high only while a request is active on the selected line, and otherwise it is left floating so that other devices can share it. The update strobe comes either from an internal timing source, which is already synchronous, or from an external pin. A configuration bit selects between them, and the external pin first passes through a two-flop synchronizer.

A small write port programs the enable mask, the clear strobes and the configuration. The six pending flags are visible at all times on a status output.

Top module: `irq_router`

## Requirements
- R1: After reset all pending flags read 0, the enable mask is 0, the line select is 0, the update source is internal, and no IRQ line is driven (`irq_en_o` is 0).
- R2: An event input that is high at a rising clock edge sets its pending bit at that edge. The bits of `pend_o` are: 0 ADC FIFO, 1 acquisition done, 2 DMA terminal count (channel A or channel B), 3 DAC FIFO, 4 DAC sequence done, 5 update falling edge.
- R3: A pending bit stays set until a write to address 1 has a 1 in that bit position. The same write leaves every bit written with a 0 unchanged.
- R4: When an event and its clear arrive in the same cycle, the event wins and the pending bit stays set.
- R5: With the internal source selected (config bit 3 = 0), a 1-to-0 transition of `upd_int_i` between two consecutive clock edges sets pending bit 5 at the second edge. A rising transition sets nothing.
- R6: With the external source selected (config bit 3 = 1), `upd_ext_i` passes through two synchronizer flops, so a falling edge sampled at edge k sets pending bit 5 at edge k+2. While the external source is selected, `upd_int_i` has no effect.
- R7: The request is active exactly when some pending bit has its enable bit set. The enable mask is at address 0, bits 5:0. Changing the mask never changes the pending flags.
- R8: Config address 2 bits 2:0 select the output line: value n drives `irq_o[n]`/`irq_en_o[n]`, where bit n stands for IRQ3, 4, 5, 7, 10, 11, 12, 15 for n = 0..7. At most one line is driven at a time.
- R9: A driven line carries logic 1. An undriven line is high-impedance, and its `irq_en_o` bit is 0.
- R10: A write to address 3 changes neither the pending flags, the enable mask nor the configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_adc_fifo_i | input | 1 | ADC FIFO service event |
| ev_acq_done_i | input | 1 | Acquisition complete or error |
| ev_dma_tc_a_i | input | 1 | DMA terminal count, channel A |
| ev_dma_tc_b_i | input | 1 | DMA terminal count, channel B |
| ev_dac_fifo_i | input | 1 | DAC FIFO service event |
| ev_dac_done_i | input | 1 | DAC sequence complete or underflow |
| upd_int_i | input | 1 | Internal update strobe (synchronous) |
| upd_ext_i | input | 1 | External update strobe (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 enable, 1 clear, 2 config |
| wr_data_i | input | 6 | Register write data |
| pend_o | output | 6 | Pending flags (status) |
| irq_en_o | output | 8 | Output driver enable per host line |
| irq_o | output | 8 | Tri-state host interrupt lines |

## Verification
The hardest situation to bring about is a source event that lands in exactly the cycle of its own clear write. A second hard case is an update-strobe falling edge that has to be timed through the two synchronizer stages while the internal strobe toggles at the same time. The stimulus builds both cases on purpose: it raises the event input and the write strobe on the same falling clock edge, and it swings the unused strobe while the selected one is in flight. A long pseudo-random phase then mixes events, clears, mask changes, source switches and line changes. A cycle-level model in the bench follows every one of these steps.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC     = 6;
  localparam int NLINES   = 8;
  localparam int SEL_W    = $clog2(NLINES);
  localparam int ADDR_W   = 2;

  localparam int SRC_ADC_FIFO = 0;
  localparam int SRC_ACQ_DONE = 1;
  localparam int SRC_DMA_TC   = 2;
  localparam int SRC_DAC_FIFO = 3;
  localparam int SRC_DAC_DONE = 4;
  localparam int SRC_UPD_FALL = 5;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_ENABLE = 2'd0,
    ADDR_CLEAR  = 2'd1,
    ADDR_CONFIG = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             use_ext;
    logic [SEL_W-1:0] line;
  } cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_router_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [N-1:0]      wr_data_i,
  output logic [N-1:0]      en_mask_o,
  output logic [N-1:0]      clr_o,
  output cfg_t              cfg_o
);
  localparam int CFG_W = $bits(cfg_t);

  logic [N-1:0] en_q, en_d;
  cfg_t         cfg_q, cfg_d;
  logic         en_we, cfg_we, clr_we;

  always_comb begin
    en_we  = wr_en_i && (wr_addr_i == ADDR_ENABLE);
    clr_we = wr_en_i && (wr_addr_i == ADDR_CLEAR);
    cfg_we = wr_en_i && (wr_addr_i == ADDR_CONFIG);
    en_d   = en_q;
    cfg_d  = cfg_q;
    if (en_we)  en_d  = wr_data_i;
    if (cfg_we) cfg_d = cfg_t'(wr_data_i[CFG_W-1:0]);
    clr_o  = clr_we ? wr_data_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (en_we)  en_q  <= en_d;
      if (cfg_we) cfg_q <= cfg_d;
    end
  end

  assign en_mask_o = en_q;
  assign cfg_o     = cfg_q;
endmodule

// File: rtl/irq_update_edge.sv
module irq_update_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic int_strobe_i,
  input  logic ext_strobe_i,
  input  logic use_ext_i,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   level_q, level_d;
  logic                   sel_level;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      assign sync_d[s] = ext_strobe_i;
    end else begin : g_next
      assign sync_d[s] = sync_q[s-1];
    end
  end

  always_comb begin
    sel_level = use_ext_i ? sync_q[LAST] : int_strobe_i;
    level_d   = sel_level;
    fall_o    = level_q & ~sel_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      level_q <= level_d;
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] event_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q, pend_d;

  for (genvar b = 0; b < N; b++) begin : g_bit
    assign pend_d[b] = event_i[b] | (pend_q[b] & ~clr_i[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[b] <= 1'b0;
      else        pend_q[b] <= pend_d[b];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_adc_fifo_i,
  input  logic              ev_acq_done_i,
  input  logic              ev_dma_tc_a_i,
  input  logic              ev_dma_tc_b_i,
  input  logic              ev_dac_fifo_i,
  input  logic              ev_dac_done_i,
  input  logic              upd_int_i,
  input  logic              upd_ext_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NSRC-1:0]   wr_data_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [NLINES-1:0] irq_en_o,
  output logic [NLINES-1:0] irq_o
);
  logic [NSRC-1:0]   en_mask;
  logic [NSRC-1:0]   clr;
  logic [NSRC-1:0]   events;
  logic [NSRC-1:0]   pend_q;
  cfg_t              cfg;
  logic              upd_fall;
  logic              request;
  logic [NLINES-1:0] drive;

  irq_cfg_regs #(.N(NSRC)) cfg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .en_mask_o (en_mask),
    .clr_o     (clr),
    .cfg_o     (cfg)
  );

  irq_update_edge #(.SYNC_STAGES(2)) upd_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .int_strobe_i (upd_int_i),
    .ext_strobe_i (upd_ext_i),
    .use_ext_i    (cfg.use_ext),
    .fall_o       (upd_fall)
  );

  always_comb begin
    events               = '0;
    events[SRC_ADC_FIFO] = ev_adc_fifo_i;
    events[SRC_ACQ_DONE] = ev_acq_done_i;
    events[SRC_DMA_TC]   = ev_dma_tc_a_i | ev_dma_tc_b_i;
    events[SRC_DAC_FIFO] = ev_dac_fifo_i;
    events[SRC_DAC_DONE] = ev_dac_done_i;
    events[SRC_UPD_FALL] = upd_fall;
  end

  irq_pending #(.N(NSRC)) pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .event_i (events),
    .clr_i   (clr),
    .pend_o  (pend_q)
  );

  assign request = |(pend_q & en_mask);

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    assign drive[l] = request && (cfg.line == SEL_W'(l));
    assign irq_o[l] = drive[l] ? 1'b1 : 1'bz;
  end

  assign irq_en_o = drive;
  assign pend_o   = pend_q;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   pend,
  input logic [NLINES-1:0] drv,
  input logic [NSRC-1:0]   en_mask,
  input logic              ev_adc,
  input logic              dma_a,
  input logic              dma_b,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [NSRC-1:0]   wr_data
);
  logic [NSRC-1:0] clr_hit;
  logic [NSRC-1:0] keep;

  assign clr_hit = (wr_en && wr_addr == 2'd1) ? wr_data : '0;
  assign keep    = pend & ~clr_hit;

  AST_ADC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_adc |=> pend[0]); // R2

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(keep)) == $past(keep))); // R3

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((dma_a || dma_b) && clr_hit[2]) |=> pend[2]); // R4

  AST_LINE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|drv) == (|(pend & en_mask))); // R7

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv)); // R8
endmodule

bind irq_router irq_router_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .pend    (pend_o),
  .drv     (irq_en_o),
  .en_mask (en_mask),
  .ev_adc  (ev_adc_fifo_i),
  .dma_a   (ev_dma_tc_a_i),
  .dma_b   (ev_dma_tc_b_i),
  .wr_en   (wr_en_i),
  .wr_addr (wr_addr_i),
  .wr_data (wr_data_i)
);

// File: tb/irq_router_tb_top.sv
module irq_router_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_adc = 0, ev_acq = 0, dma_a = 0, dma_b = 0, ev_dacf = 0, ev_dacd = 0;
  logic       upd_int = 0, upd_ext = 0;
  logic       wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [5:0] wr_data = 0;
  logic [5:0] pend;
  logic [7:0] irq_en;
  logic [7:0] irq;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    compare_on = 0;

  // behavioural reference state
  bit [5:0] m_pend, m_en;
  int       m_sel;
  bit       m_ext;
  bit       s1, s2, prev;
  bit [7:0] exp_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_adc_fifo_i(ev_adc), .ev_acq_done_i(ev_acq),
    .ev_dma_tc_a_i(dma_a), .ev_dma_tc_b_i(dma_b),
    .ev_dac_fifo_i(ev_dacf), .ev_dac_done_i(ev_dacd),
    .upd_int_i(upd_int), .upd_ext_i(upd_ext),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pend_o(pend), .irq_en_o(irq_en), .irq_o(irq)
  );

  task automatic chk(bit ok, string t, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_sel = 0; m_ext = 0; s1 = 0; s2 = 0; prev = 0;
    end else begin
      bit cur, fall;
      bit [5:0] ev, clrv;
      cur  = m_ext ? s2 : upd_int;
      fall = prev && !cur;
      ev   = {fall, ev_dacd, ev_dacf, dma_a | dma_b, ev_acq, ev_adc};
      clrv = (wr_en && wr_addr == 1) ? wr_data : 6'd0;
      for (int b = 0; b < 6; b++)
        if (ev[b]) m_pend[b] = 1;
        else if (clrv[b]) m_pend[b] = 0;
      prev = cur;
      s2 = s1; s1 = upd_ext;
      if (wr_en && wr_addr == 0) m_en = wr_data;
      if (wr_en && wr_addr == 2) begin m_sel = int'(wr_data[2:0]); m_ext = wr_data[3]; end
    end
  end

  always @(negedge clk) begin
    if (compare_on) begin
      exp_drv = (|(m_pend & m_en)) ? (8'd1 << m_sel) : 8'd0;
      chk(pend === m_pend, tag, "pend_o", {2'b0, pend}, {2'b0, m_pend});
      chk(irq_en === exp_drv, tag, "irq_en_o R7 R8", irq_en, exp_drv);
      for (int l = 0; l < 8; l++)
        if (exp_drv[l]) chk(irq[l] === 1'b1, "R9", "irq_o level", irq, exp_drv);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [5:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL R1 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit [31:0] lfsr;
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1: reset state
    chk(pend === 6'd0, "R1", "reset pend", {2'b0, pend}, 8'h00);
    chk(irq_en === 8'd0, "R1", "reset drive", irq_en, 8'h00);
    compare_on = 1;

    // R2 / R3: each source, then individual clears
    tag = "R2";
    wr(0, 6'h3f);
    ev_adc = 1; cyc(); ev_adc = 0;
    ev_acq = 1; cyc(); ev_acq = 0;
    dma_b  = 1; cyc(); dma_b  = 0;
    ev_dacf = 1; cyc(); ev_dacf = 0;
    ev_dacd = 1; cyc(); ev_dacd = 0;
    cyc(2);
    chk(pend === 6'h1f, "R2", "five sources pending", {2'b0, pend}, 8'h1f);
    tag = "R3";
    wr(1, 6'h04);
    chk(pend === 6'h1b, "R3", "selective clear", {2'b0, pend}, 8'h1b);
    tag = "R2";
    dma_a = 1; cyc(); dma_a = 0; cyc();
    chk(pend[2] === 1'b1, "R2", "dma A sets bit2", {7'b0, pend[2]}, 8'h01);

    // R8: sweep line select with request active
    tag = "R8";
    for (int s = 0; s < 8; s++) begin
      wr(2, 6'(s));
      chk(irq_en === (8'd1 << s), "R8", "line select", irq_en, 8'd1 << s);
    end

    // R7: masking
    tag = "R7";
    wr(0, 6'h00);
    chk(irq_en === 8'd0, "R7", "masked no drive", irq_en, 8'h00);
    chk(pend === 6'h1f, "R7", "mask keeps pend", {2'b0, pend}, 8'h1f);
    wr(1, 6'h3f);
    wr(0, 6'h20);
    ev_adc = 1; cyc(); ev_adc = 0; cyc();
    chk(irq_en === 8'd0, "R7", "unenabled source", irq_en, 8'h00);
    wr(1, 6'h3f);

    // R4: event in the clear cycle
    tag = "R4";
    wr(0, 6'h3f);
    dma_a = 1; cyc(); dma_a = 0;
    @(negedge clk); wr_en = 1; wr_addr = 1; wr_data = 6'h04; dma_b = 1;
    @(negedge clk); wr_en = 0; wr_data = 0; dma_b = 0;
    chk(pend[2] === 1'b1, "R4", "event beats clear", {7'b0, pend[2]}, 8'h01);
    wr(1, 6'h3f);

    // R5: internal strobe edges
    tag = "R5";
    upd_int = 1; cyc(2);
    chk(pend[5] === 1'b0, "R5", "rise ignored", {7'b0, pend[5]}, 8'h00);
    upd_int = 0; cyc(1);
    chk(pend[5] === 1'b1, "R5", "fall sets bit5", {7'b0, pend[5]}, 8'h01);
    wr(1, 6'h20);

    // R6: external strobe via synchronizer, internal ignored
    tag = "R6";
    wr(2, 6'h08);
    upd_ext = 1; cyc(4);
    wr(1, 6'h20);
    upd_int = 1; cyc(2); upd_int = 0; cyc(2);
    chk(pend[5] === 1'b0, "R6", "internal ignored", {7'b0, pend[5]}, 8'h00);
    upd_ext = 0; cyc(2);
    chk(pend[5] === 1'b0, "R6", "not yet through sync", {7'b0, pend[5]}, 8'h00);
    cyc(1);
    chk(pend[5] === 1'b1, "R6", "ext fall after sync", {7'b0, pend[5]}, 8'h01);

    // R10: spare address write
    tag = "R10";
    wr(2, 6'h03);
    wr(3, 6'h3f);
    cyc();
    chk(pend === 6'h20, "R10", "spare write pend", {2'b0, pend}, 8'h20);
    chk(irq_en === 8'h08, "R10", "spare write cfg", irq_en, 8'h08);

    // pseudo-random mix
    tag = "R3/R7";
    lfsr = 32'h1ace_b00c;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ev_adc  = lfsr[0] & lfsr[7];
      ev_acq  = lfsr[1] & lfsr[9];
      dma_a   = lfsr[2] & lfsr[11] & lfsr[5];
      dma_b   = lfsr[3] & lfsr[13] & lfsr[6];
      ev_dacf = lfsr[4] & lfsr[15];
      ev_dacd = lfsr[5] & lfsr[17] & lfsr[8];
      if (lfsr[19:18] == 0) upd_int = ~upd_int;
      if (lfsr[21:20] == 0) upd_ext = ~upd_ext;
      wr_en   = (lfsr[25:23] == 0);
      wr_addr = lfsr[27:26];
      wr_data = lfsr[31:26] ^ lfsr[12:7];
    end
    @(negedge clk);
    wr_en = 0; ev_adc = 0; ev_acq = 0; dma_a = 0; dma_b = 0; ev_dacf = 0; ev_dacd = 0;
    cyc(4);
    compare_on = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule